// File: doc/BRIEF.md
# Amplifier-channel status and interrupt registers

This block is the bus-side register file for a small group of analog amplifier channels. Over an APB slave port, software turns each amplifier on, opens its Schmitt-trigger digital output path, and arms a per-channel interrupt. The raw comparator-style digital output of each channel arrives asynchronously. The block brings it into the bus clock domain through a flop chain and watches it for any change. A change seen while that channel's output buffer is enabled sets a sticky flag. Software clears the flag by writing a one to it. A single interrupt line is asserted whenever an enabled channel holds a flag.

The block also holds the controls for an external calibration engine: a start bit, a two-bit clock select and a reference-select bit for each channel. A start bit is accepted only while the channel's amplifier is enabled. The block drops the start bit itself when the engine returns a done pulse for that channel. On that pulse the block also latches the NMOS and PMOS fail results and raises the channel's done status bit. The done bit reads 0 from the moment a new calibration starts.

Top module: `amp_chan_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `irq` is 0, and `amp_en`, `buf_en`, `cal_start`, `cal_clksel` and `cal_vref` are all 0.
- R2: The control word (byte address 0x0) is read/write. Channel i has its amplifier enable at bit i, its output-buffer enable at bit 4+i and its interrupt enable at bit 8+i. All other bits read 0. The enables drive `amp_en` and `buf_en`.
- R3: Status (0x4) bit i shows `ana_dout[i]` after two flops in the bus clock domain. An input changed just before edge k reads back after edge k+1. The bit reads 0 while that channel's buffer enable is 0.
- R4: Status bit 4+i is a sticky flag. It is set on either edge of the synchronized output, one clock after that edge reaches the status bit, provided the buffer enable is 1. A change that happens while the buffer is disabled sets no flag, and re-enabling the buffer later does not set one either.
- R5: Writing 1 to a status flag bit clears it. Writing 0 leaves it unchanged.
- R6: If a flag set and a write-one-to-clear of that flag fall on the same clock edge, the flag ends up set.
- R7: `irq` is 1 exactly when some channel has both its flag set and its interrupt enable at 1. With all interrupt enables at 0, `irq` stays 0.
- R8: Calibration control (0x8) bit i is channel i's start bit and drives `cal_start[i]`. A 1 written while that channel's amplifier enable is 0 is ignored and reads back 0.
- R9: Calibration status (0x0C) has, for channel i, a done bit at 4i, an NMOS fail bit at 4i+1 and a PMOS fail bit at 4i+2. A `cal_done[i]` pulse while the start bit is 1 clears the start bit, sets done, and captures `cal_nfail[i]` and `cal_pfail[i]`. Starting a channel clears its done bit. A done pulse while the start bit is 0 changes nothing.
- R10: Calibration control bits [4+2i+1:4+2i] are channel i's clock select and bit 16+i is its reference select. Both are read/write and drive `cal_clksel[2i+1:2i]` and `cal_vref[i]`.
- R11: Calibration status is read-only. Writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, combinational from the address |
| ana_dout | input | N_CH | Raw asynchronous digital output of each amplifier |
| cal_done | input | N_CH | One-cycle done pulse per channel from the calibration engine |
| cal_nfail | input | N_CH | NMOS fail result, valid with `cal_done` |
| cal_pfail | input | N_CH | PMOS fail result, valid with `cal_done` |
| amp_en | output | N_CH | Amplifier enables |
| buf_en | output | N_CH | Schmitt-trigger output buffer enables |
| cal_start | output | N_CH | Calibration start requests |
| cal_clksel | output | 2*N_CH | Calibration clock select, two bits per channel |
| cal_vref | output | N_CH | Calibration reference select |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the defaults: three channels, a two-stage synchronizer and a four-bit address. With three channels, all three status nibbles and all three clock-select pairs hold distinct patterns, so a bit landing in the wrong lane shows up in the read data. The two-stage depth fixes the delay from input to flag at a known count of edges. That lets the bench land a clear write on the exact edge where a flag is set, and it lets the bench see the status bit on the cycle before the synchronized value arrives and on the cycle it arrives.

// File: rtl/amp_chan_regs_pkg.sv
// Package: address offsets and field bases shared by the register block,
// its channel slices and its checker. Offsets are byte addresses.
package amp_chan_regs_pkg;
    localparam int unsigned OFS_CTL      = 0;
    localparam int unsigned OFS_STAT     = 4;
    localparam int unsigned OFS_CALCTL   = 8;
    localparam int unsigned OFS_CALST    = 12;
    // control word field bases
    localparam int unsigned BUF_BASE     = 4;
    localparam int unsigned IE_BASE      = 8;
    // status word field base for the sticky flags
    localparam int unsigned FLAG_BASE    = 4;
    // calibration control field bases
    localparam int unsigned CLKSEL_BASE  = 4;
    localparam int unsigned VREF_BASE    = 16;
    // calibration status: one nibble per channel
    localparam int unsigned CALST_STRIDE = 4;
    localparam int unsigned MAX_CH       = 4;
endpackage

// File: rtl/amp_sync_edge.sv
// Module: amp_sync_edge
// Brings one asynchronous digital output into the clock domain through a
// chain of STAGES flops and keeps a sticky change flag. Assumes STAGES >= 2.
// The flag is set on any edge of the synchronized value while buf_en is 1,
// and the set wins over a clear request in the same cycle.
module amp_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic buf_en,
    input  logic flag_clr,
    output logic sync_o,
    output logic flag_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              flag_q;
    logic              toggle;

    // edge of the synchronized value, gated by the buffer enable
    assign toggle = (chain_q[STAGES-1] ^ prev_q) & buf_en;

    // shift the synchronizer, remember the last value, update the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_in};
            prev_q  <= chain_q[STAGES-1];
            flag_q  <= toggle | (flag_q & ~flag_clr);
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign flag_o = flag_q;
endmodule

// File: rtl/amp_cal_chan.sv
// Module: amp_cal_chan
// Calibration handshake for one channel. It holds the start request, accepts
// it only while the amplifier is enabled, and drops it on the engine's done
// pulse, when it also latches the fail results. Assumes done_in is a
// one-cycle pulse; a pulse while no start is pending is ignored.
module amp_cal_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_start,
    input  logic amp_en,
    input  logic done_in,
    input  logic nfail_in,
    input  logic pfail_in,
    output logic start_o,
    output logic done_o,
    output logic nfail_o,
    output logic pfail_o
);
    logic start_q, done_q, nfail_q, pfail_q;
    logic accept;

    assign accept = wr_start & amp_en;

    // start/done state: completion takes priority over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            nfail_q <= 1'b0;
            pfail_q <= 1'b0;
        end else if (done_in && start_q) begin
            start_q <= 1'b0;
            done_q  <= 1'b1;
            nfail_q <= nfail_in;
            pfail_q <= pfail_in;
        end else if (wr_en) begin
            start_q <= accept;
            if (accept) begin
                done_q <= 1'b0;
            end
        end
    end

    assign start_o = start_q;
    assign done_o  = done_q;
    assign nfail_o = nfail_q;
    assign pfail_o = pfail_q;
endmodule

// File: rtl/amp_chan_regs.sv
// Module: amp_chan_regs
// APB register block for N_CH amplifier channels: enables, synchronized
// digital outputs with sticky change flags, a combined interrupt, and the
// calibration controls and results. Assumes N_CH <= 4 so every field fits its
// nibble, ADDR_W >= 4, and a single-cycle APB slave (no wait states).
module amp_chan_regs
    import amp_chan_regs_pkg::*;
#(
    parameter int unsigned N_CH        = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 4
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    input  logic [N_CH-1:0]     ana_dout,
    input  logic [N_CH-1:0]     cal_done,
    input  logic [N_CH-1:0]     cal_nfail,
    input  logic [N_CH-1:0]     cal_pfail,
    output logic [N_CH-1:0]     amp_en,
    output logic [N_CH-1:0]     buf_en,
    output logic [N_CH-1:0]     cal_start,
    output logic [2*N_CH-1:0]   cal_clksel,
    output logic [N_CH-1:0]     cal_vref,
    output logic                irq
);
    localparam int unsigned SEL_W = 2 * N_CH;

    logic [ADDR_W-1:0] word_addr;
    logic              wr_acc;
    logic              wr_ctl, wr_stat, wr_calctl;
    logic [N_CH-1:0]   amp_q, buf_q, ie_q;
    logic [SEL_W-1:0]  clksel_q;
    logic [N_CH-1:0]   vref_q;
    logic [N_CH-1:0]   sync_q, flag_q, flag_clr;
    logic [N_CH-1:0]   start_q, cdone_q, nfail_q, pfail_q;
    logic              unused_bits;

    // address decode of the access phase
    assign word_addr = {paddr[ADDR_W-1:2], 2'b00};
    assign wr_acc    = psel & penable & pwrite;
    assign wr_ctl    = wr_acc && (word_addr == ADDR_W'(OFS_CTL));
    assign wr_stat   = wr_acc && (word_addr == ADDR_W'(OFS_STAT));
    assign wr_calctl = wr_acc && (word_addr == ADDR_W'(OFS_CALCTL));
    assign flag_clr  = wr_stat ? pwdata[FLAG_BASE +: N_CH] : '0;

    // control word: amplifier, buffer and interrupt enables
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            amp_q <= '0;
            buf_q <= '0;
            ie_q  <= '0;
        end else if (wr_ctl) begin
            amp_q <= pwdata[N_CH-1:0];
            buf_q <= pwdata[BUF_BASE +: N_CH];
            ie_q  <= pwdata[IE_BASE +: N_CH];
        end
    end

    // calibration clock and reference selects
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            clksel_q <= '0;
            vref_q   <= '0;
        end else if (wr_calctl) begin
            clksel_q <= pwdata[CLKSEL_BASE +: SEL_W];
            vref_q   <= pwdata[VREF_BASE +: N_CH];
        end
    end

    // one synchronizer and one calibration slice per channel
    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        amp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (pclk),
            .rst_n    (presetn),
            .raw_in   (ana_dout[g]),
            .buf_en   (buf_q[g]),
            .flag_clr (flag_clr[g]),
            .sync_o   (sync_q[g]),
            .flag_o   (flag_q[g])
        );
        amp_cal_chan u_cal (
            .clk      (pclk),
            .rst_n    (presetn),
            .wr_en    (wr_calctl),
            .wr_start (pwdata[g]),
            .amp_en   (amp_q[g]),
            .done_in  (cal_done[g]),
            .nfail_in (cal_nfail[g]),
            .pfail_in (cal_pfail[g]),
            .start_o  (start_q[g]),
            .done_o   (cdone_q[g]),
            .nfail_o  (nfail_q[g]),
            .pfail_o  (pfail_q[g])
        );
    end

    // read mux; unimplemented bits and addresses read 0
    always_comb begin
        prdata = '0;
        if (word_addr == ADDR_W'(OFS_CTL)) begin
            for (int i = 0; i < N_CH; i++) begin
                prdata[i]            = amp_q[i];
                prdata[BUF_BASE + i] = buf_q[i];
                prdata[IE_BASE + i]  = ie_q[i];
            end
        end else if (word_addr == ADDR_W'(OFS_STAT)) begin
            for (int i = 0; i < N_CH; i++) begin
                prdata[i]             = sync_q[i] & buf_q[i];
                prdata[FLAG_BASE + i] = flag_q[i];
            end
        end else if (word_addr == ADDR_W'(OFS_CALCTL)) begin
            for (int i = 0; i < N_CH; i++) begin
                prdata[i]             = start_q[i];
                prdata[VREF_BASE + i] = vref_q[i];
            end
            prdata[CLKSEL_BASE +: SEL_W] = clksel_q;
        end else if (word_addr == ADDR_W'(OFS_CALST)) begin
            for (int i = 0; i < N_CH; i++) begin
                prdata[CALST_STRIDE * i]     = cdone_q[i];
                prdata[CALST_STRIDE * i + 1] = nfail_q[i];
                prdata[CALST_STRIDE * i + 2] = pfail_q[i];
            end
        end
    end

    // outputs to the analog side and the interrupt controller
    assign amp_en      = amp_q;
    assign buf_en      = buf_q;
    assign cal_start   = start_q;
    assign cal_clksel  = clksel_q;
    assign cal_vref    = vref_q;
    assign irq         = |(flag_q & ie_q);
    assign unused_bits = ^{pwdata, paddr[1:0]};
endmodule

// File: rtl/amp_chan_regs_chk.sv
// Module: amp_chan_regs_chk
// Property checker bound into amp_chan_regs. It watches the APB port, the
// calibration handshake and the flag and enable state of the block.
module amp_chan_regs_chk
    import amp_chan_regs_pkg::*;
#(
    parameter int unsigned N_CH   = 3,
    parameter int unsigned ADDR_W = 4
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [N_CH-1:0]   cal_done,
    input logic [N_CH-1:0]   cal_start,
    input logic [N_CH-1:0]   amp_en,
    input logic [N_CH-1:0]   flag_q,
    input logic [N_CH-1:0]   buf_q,
    input logic [N_CH-1:0]   ie_q,
    input logic              irq
);
    logic [N_CH-1:0] clr_req;
    logic            unused_chk;

    // clear request seen on the bus, decoded independently of the block
    assign clr_req = (psel && penable && pwrite &&
                      (paddr[ADDR_W-1:2] == (ADDR_W-2)'(OFS_STAT >> 2)))
                     ? pwdata[FLAG_BASE +: N_CH] : '0;
    assign unused_chk = ^{pwdata, paddr[1:0]};

    // R4
    flag_needs_buf_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (flag_q & ~$past(flag_q) & ~$past(buf_q)) == '0);

    // R5
    flag_clear_by_w1c_chk: assert property (@(posedge pclk) disable iff (!presetn)
        ($past(flag_q) & ~flag_q & ~$past(clr_req)) == '0);

    // R7
    irq_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (ie_q == '0) |-> !irq);

    // R8
    start_needs_amp_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (cal_start & ~$past(cal_start) & ~$past(amp_en)) == '0);

    // R9
    start_self_clear_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (|(cal_done & cal_start)) |=> ((cal_start & $past(cal_done & cal_start)) == '0));
endmodule

bind amp_chan_regs amp_chan_regs_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) chk_i (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .cal_done  (cal_done),
    .cal_start (cal_start),
    .amp_en    (amp_en),
    .flag_q    (flag_q),
    .buf_q     (buf_q),
    .ie_q      (ie_q),
    .irq       (irq)
);

// File: tb/amp_chan_regs_tb_top.sv
// Directed bench for amp_chan_regs: one task per scenario, each checking its
// own results against values worked out from the requirements.
module amp_chan_regs_tb_top;
    localparam int N_CH = 3;
    localparam int AW   = 4;

    logic            pclk = 1'b0;
    logic            presetn = 1'b0;
    logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0]   paddr = '0;
    logic [31:0]     pwdata = '0;
    logic [31:0]     prdata;
    logic [N_CH-1:0] ana_dout = '0;
    logic [N_CH-1:0] cal_done = '0, cal_nfail = '0, cal_pfail = '0;
    logic [N_CH-1:0] amp_en, buf_en, cal_start, cal_vref;
    logic [2*N_CH-1:0] cal_clksel;
    logic            irq;

    int checks = 0;
    int errors = 0;

    always #2 pclk = ~pclk;

    amp_chan_regs #(.N_CH(N_CH), .SYNC_STAGES(2), .ADDR_W(AW)) dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ana_dout(ana_dout), .cal_done(cal_done), .cal_nfail(cal_nfail),
        .cal_pfail(cal_pfail), .amp_en(amp_en), .buf_en(buf_en),
        .cal_start(cal_start), .cal_clksel(cal_clksel), .cal_vref(cal_vref),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge pclk);
    endtask

    task automatic set_input(input logic [N_CH-1:0] v);
        @(negedge pclk);
        ana_dout = v;
        wait_cyc(4);
    endtask

    task automatic pulse_done(input logic [N_CH-1:0] m, input logic [N_CH-1:0] nf, input logic [N_CH-1:0] pf);
        @(negedge pclk);
        cal_done = m; cal_nfail = nf; cal_pfail = pf;
        @(negedge pclk);
        cal_done = '0; cal_nfail = '0; cal_pfail = '0;
    endtask

    task automatic t_reset();
        read_check("R1 ctl", 4'h0, 32'h0);
        read_check("R1 status", 4'h4, 32'h0);
        read_check("R1 calctl", 4'h8, 32'h0);
        read_check("R1 calst", 4'hC, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 outputs", {amp_en, buf_en, cal_start, cal_vref, cal_clksel}, 32'h0);
    endtask

    task automatic t_ctl();
        apb_write(4'h0, 32'hFFFF_FFFF);
        read_check("R2 ctl all ones", 4'h0, 32'h0000_0777);
        check("R2 amp_en", {29'b0, amp_en}, 32'h7);
        check("R2 buf_en", {29'b0, buf_en}, 32'h7);
        apb_write(4'h0, 32'h0000_0077);
        read_check("R2 ctl no ie", 4'h0, 32'h0000_0077);
    endtask

    task automatic t_sync();
        // peek the status word through the combinational read path
        @(negedge pclk);
        paddr = 4'h4;
        ana_dout = 3'b101;
        @(negedge pclk);
        check("R3 one edge not yet", {29'b0, prdata[2:0]}, 32'h0);
        @(negedge pclk);
        check("R3 two edges", {29'b0, prdata[2:0]}, 32'h5);
        @(negedge pclk);
        check("R4 rising flags", prdata, 32'h55);
        apb_write(4'h4, 32'h50);
        read_check("R5 clear both", 4'h4, 32'h05);
        set_input(3'b001);
        read_check("R4 falling flag", 4'h4, 32'h41);
    endtask

    task automatic t_w1c();
        set_input(3'b011);
        read_check("R5 setup", 4'h4, 32'h63);
        apb_write(4'h4, 32'h00);
        read_check("R5 write zero keeps", 4'h4, 32'h63);
        apb_write(4'h4, 32'h20);
        read_check("R5 clear one", 4'h4, 32'h43);
        apb_write(4'h4, 32'h40);
        read_check("R5 clear other", 4'h4, 32'h03);
    endtask

    task automatic t_bufoff();
        apb_write(4'h0, 32'h07);
        read_check("R3 masked when off", 4'h4, 32'h00);
        set_input(3'b100);
        read_check("R4 no flag when off", 4'h4, 32'h00);
        apb_write(4'h0, 32'h77);
        read_check("R4 no flag on reenable", 4'h4, 32'h04);
    endtask

    task automatic t_race();
        // toggle, then a write whose access edge is the third edge after it
        @(negedge pclk);
        ana_dout = 3'b110;
        apb_write(4'h4, 32'h20);
        read_check("R6 set beats clear", 4'h4, 32'h26);
        apb_write(4'h4, 32'h20);
        read_check("R6 later clear", 4'h4, 32'h06);
    endtask

    task automatic t_irq();
        set_input(3'b111);
        read_check("R7 flag set", 4'h4, 32'h17);
        check("R7 no ie no irq", {31'b0, irq}, 32'h0);
        apb_write(4'h0, 32'h277);
        check("R7 other ch ie", {31'b0, irq}, 32'h0);
        apb_write(4'h0, 32'h177);
        check("R7 irq asserted", {31'b0, irq}, 32'h1);
        apb_write(4'h4, 32'h10);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_cal();
        apb_write(4'h0, 32'h070);
        apb_write(4'h8, 32'h7);
        read_check("R8 start ignored", 4'h8, 32'h0);
        check("R8 cal_start low", {29'b0, cal_start}, 32'h0);
        apb_write(4'h0, 32'h077);
        apb_write(4'h8, 32'h0005_0363);
        read_check("R10 calctl", 4'h8, 32'h0005_0363);
        check("R8 cal_start", {29'b0, cal_start}, 32'h3);
        check("R10 clksel", {26'b0, cal_clksel}, 32'h36);
        check("R10 vref", {29'b0, cal_vref}, 32'h5);
        read_check("R9 calibrating", 4'hC, 32'h0);
        pulse_done(3'b001, 3'b001, 3'b000);
        read_check("R9 ch0 self clear", 4'h8, 32'h0005_0362);
        read_check("R9 ch0 result", 4'hC, 32'h003);
        pulse_done(3'b010, 3'b000, 3'b010);
        read_check("R9 ch1 self clear", 4'h8, 32'h0005_0360);
        read_check("R9 ch1 result", 4'hC, 32'h053);
        pulse_done(3'b100, 3'b100, 3'b100);
        read_check("R9 idle done ignored", 4'hC, 32'h053);
        apb_write(4'h8, 32'h0005_0361);
        read_check("R9 restart clears done", 4'hC, 32'h052);
    endtask

    task automatic t_ro();
        apb_write(4'hC, 32'hFFFF_FFFF);
        read_check("R11 calst unchanged", 4'hC, 32'h052);
        read_check("R11 ctl unchanged", 4'h0, 32'h077);
        read_check("R11 calctl unchanged", 4'h8, 32'h0005_0361);
    endtask

    initial begin
        wait_cyc(5);
        presetn = 1'b1;
        t_reset();
        t_ctl();
        t_sync();
        t_w1c();
        t_bufoff();
        t_race();
        t_irq();
        t_cal();
        t_ro();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule